// File: doc/BRIEF.md
# Time-Gain Compensation Sequencer

This block schedules the full-scale and gain settings of an ultrasound receive front-end across one receive window. A single-cycle trigger starts the window. From then on the block issues a fixed number of evenly spaced updates. Each update presents a new pair of 12-bit reference codes, one upper and one lower, for two external reference DACs, together with a 2-bit select for the second-stage amplifier gain.

The two references sit symmetrically about a fixed common-mode code. The distance between each reference and common mode is read from a loadable offset table, one entry per update. As the window goes on this distance normally shrinks, so the converter full scale follows the weakening echoes. The gain select moves up through four levels at programmable update indices, which keeps the loop gain of the converter roughly constant.

A one-cycle strobe marks every update so the DACs can latch the new codes. The offset table and the three switch indices can be written only while no window is running. After the last update the outputs hold until the next trigger.

Top module: `tgc_sequencer`

## Requirements
- R1: After synchronous reset, both reference outputs equal CM_CODE, gain_sel_o is 0, upd_stb_o and busy_o are 0, every table entry is 0, and the switch indices for levels 0, 1 and 2 are NUM_STEPS/4, NUM_STEPS/2 and 3*NUM_STEPS/4.
- R2: A trigger sampled high while idle sets busy_o, and upd_stb_o rises on the next cycle with the outputs for update index 0.
- R3: A window contains exactly NUM_STEPS updates, for indices 0 to NUM_STEPS-1 in order, with STEP_CYCLES cycles between consecutive strobes; each strobe is high for one cycle.
- R4: For update k, with offset table entry k written as d, ref_hi_o = CM_CODE + d and ref_lo_o = CM_CODE - d, and both change in the same cycle.
- R5: The references saturate: ref_hi_o is limited to 2^CODE_W-1, and ref_lo_o is 0 when d exceeds CM_CODE.
- R6: gain_sel_o codes 0, 1, 2, 3 select 9, 16, 24 and 33 dB. The level is 0 at the start of a window. At each update it advances by exactly one if it is below 3 and the update index is at least the switch index of the current level. It therefore never decreases and moves by at most one step per update.
- R7: busy_o stays high for exactly NUM_STEPS*STEP_CYCLES cycles per window. Afterwards all outputs hold their values, with no strobe, until the next trigger.
- R8: A trigger while busy_o is high has no effect on the running window.
- R9: Table writes (tbl_we_i, entry tbl_addr_i) and switch writes (sw_we_i, sw_sel_i 0/1/2 picks level 0/1/2, sw_sel_i 3 is ignored) take effect only when busy_o is low. They are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Window start pulse |
| tbl_we_i | input | 1 | Offset table write enable |
| tbl_addr_i | input | IDX_W | Offset table entry index |
| tbl_data_i | input | CODE_W | Offset value to write |
| sw_we_i | input | 1 | Switch index write enable |
| sw_sel_i | input | 2 | Which gain level's switch index to write |
| sw_data_i | input | IDX_W | Switch index value |
| ref_hi_o | output | CODE_W | Upper reference code |
| ref_lo_o | output | CODE_W | Lower reference code |
| gain_sel_o | output | 2 | Second-stage gain select |
| upd_stb_o | output | 1 | One-cycle strobe for each update |
| busy_o | output | 1 | Window in progress |

## Verification
The hardest conditions to reach are the ones where something must not happen in the middle of a window: a table write, a switch write or a second trigger landing while updates are running. The bench issues all three partway through a window. It then runs a second window that expects the untouched contents, so any leak shows up as a wrong code or an extra strobe. Saturation and out-of-order or equal switch indices are reached by loading a table with offsets at and beyond the common-mode code, and switch indices with level 1 equal to level 0 and level 2 below both.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
    typedef logic [1:0] gain_t;
    localparam gain_t GAIN_MAX   = 2'd3;
    localparam int    NUM_SWITCH = 3;
endpackage

// File: rtl/tgc_offset_table.sv
module tgc_offset_table #(
    parameter int NUM_STEPS = 125,
    parameter int CODE_W    = 12,
    parameter int IDX_W     = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [CODE_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [CODE_W-1:0] rdata_o
);
    typedef logic [NUM_STEPS-1:0][CODE_W-1:0] mem_t;
    mem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i && !busy_i && (int'(waddr_i) < NUM_STEPS))
            mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) mem_q <= '0;
        else     mem_q <= mem_d;
    end

    assign rdata_o = (int'(raddr_i) < NUM_STEPS) ? mem_q[raddr_i] : '0;

    // R9: contents are frozen while a window runs
    p_tbl_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(mem_q));
endmodule

// File: rtl/tgc_gain_stepper.sv
module tgc_gain_stepper
    import tgc_pkg::*;
#(
    parameter int NUM_STEPS = 125,
    parameter int IDX_W     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_i,
    input  logic             sw_we_i,
    input  logic [1:0]       sw_sel_i,
    input  logic [IDX_W-1:0] sw_data_i,
    input  gain_t            level_i,
    input  logic [IDX_W-1:0] idx_i,
    output gain_t            level_o
);
    typedef logic [NUM_SWITCH-1:0][IDX_W-1:0] sw_t;
    sw_t sw_d, sw_q;
    sw_t sw_rst;

    for (genvar g = 0; g < NUM_SWITCH; g++) begin : g_rst
        assign sw_rst[g] = IDX_W'(NUM_STEPS * (g + 1) / 4);
    end

    always_comb begin
        sw_d = sw_q;
        if (sw_we_i && !busy_i && (int'(sw_sel_i) < NUM_SWITCH))
            sw_d[sw_sel_i] = sw_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) sw_q <= sw_rst;
        else     sw_q <= sw_d;
    end

    logic [IDX_W-1:0] thr;
    always_comb begin
        case (level_i)
            2'd0:    thr = sw_q[0];
            2'd1:    thr = sw_q[1];
            2'd2:    thr = sw_q[2];
            default: thr = '0;
        endcase
        level_o = level_i;
        if ((level_i != GAIN_MAX) && (idx_i >= thr))
            level_o = level_i + 2'd1;
    end

    // R9: switch indices are frozen while a window runs
    p_sw_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(sw_q));
endmodule

// File: rtl/tgc_ref_calc.sv
module tgc_ref_calc #(
    parameter int CODE_W  = 12,
    parameter int CM_CODE = 2048
) (
    input  logic [CODE_W-1:0] off_i,
    output logic [CODE_W-1:0] hi_o,
    output logic [CODE_W-1:0] lo_o
);
    localparam logic [CODE_W-1:0] CM_C = CODE_W'(CM_CODE);
    logic [CODE_W:0] sum;

    always_comb begin
        sum  = {1'b0, off_i} + {1'b0, CM_C};
        hi_o = sum[CODE_W] ? '1 : sum[CODE_W-1:0];
        lo_o = (off_i > CM_C) ? '0 : (CM_C - off_i);
    end

    // R5: saturation limits of the two codes
    always_comb begin
        p_lo_floor_r5: assert ((off_i <= CM_C) || (lo_o == '0));
    end
endmodule

// File: rtl/tgc_sequencer.sv
module tgc_sequencer
    import tgc_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int NUM_STEPS   = 125,
    parameter int STEP_CYCLES = 320,
    parameter int CM_CODE     = 2048,
    localparam int IDX_W      = $clog2(NUM_STEPS),
    localparam int CNT_W      = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic              tbl_we_i,
    input  logic [IDX_W-1:0]  tbl_addr_i,
    input  logic [CODE_W-1:0] tbl_data_i,
    input  logic              sw_we_i,
    input  logic [1:0]        sw_sel_i,
    input  logic [IDX_W-1:0]  sw_data_i,
    output logic [CODE_W-1:0] ref_hi_o,
    output logic [CODE_W-1:0] ref_lo_o,
    output logic [1:0]        gain_sel_o,
    output logic              upd_stb_o,
    output logic              busy_o
);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(STEP_CYCLES - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(NUM_STEPS - 1);
    localparam logic [CODE_W-1:0] CM_C     = CODE_W'(CM_CODE);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic              stb;
        logic [CODE_W-1:0] hi;
        logic [CODE_W-1:0] lo;
        gain_t             gain;
    } seq_t;

    seq_t s_d, s_q;

    logic              start;
    logic [IDX_W-1:0]  eval_idx;
    gain_t             eval_lvl;
    gain_t             next_lvl;
    logic [CODE_W-1:0] off_rd;
    logic [CODE_W-1:0] hi_calc;
    logic [CODE_W-1:0] lo_calc;

    assign start    = trig_i && !s_q.busy;
    assign eval_idx = start ? '0 : (s_q.idx + 1'b1);
    assign eval_lvl = start ? '0 : s_q.gain;

    tgc_offset_table #(
        .NUM_STEPS(NUM_STEPS), .CODE_W(CODE_W), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst(rst), .busy_i(s_q.busy),
        .we_i(tbl_we_i), .waddr_i(tbl_addr_i), .wdata_i(tbl_data_i),
        .raddr_i(eval_idx), .rdata_o(off_rd)
    );

    tgc_gain_stepper #(
        .NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W)
    ) u_gain (
        .clk(clk), .rst(rst), .busy_i(s_q.busy),
        .sw_we_i(sw_we_i), .sw_sel_i(sw_sel_i), .sw_data_i(sw_data_i),
        .level_i(eval_lvl), .idx_i(eval_idx), .level_o(next_lvl)
    );

    tgc_ref_calc #(
        .CODE_W(CODE_W), .CM_CODE(CM_CODE)
    ) u_ref (
        .off_i(off_rd), .hi_o(hi_calc), .lo_o(lo_calc)
    );

    always_comb begin
        logic apply;
        s_d     = s_q;
        s_d.stb = 1'b0;
        apply   = 1'b0;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.idx  = '0;
            apply    = 1'b1;
        end else if (s_q.busy) begin
            if (s_q.cnt == CNT_LAST) begin
                s_d.cnt = '0;
                if (s_q.idx == IDX_LAST) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.idx = eval_idx;
                    apply   = 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (apply) begin
            s_d.stb  = 1'b1;
            s_d.hi   = hi_calc;
            s_d.lo   = lo_calc;
            s_d.gain = next_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{busy: 1'b0, cnt: '0, idx: '0, stb: 1'b0,
                     hi: CM_C, lo: CM_C, gain: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ref_hi_o   = s_q.hi;
    assign ref_lo_o   = s_q.lo;
    assign gain_sel_o = s_q.gain;
    assign upd_stb_o  = s_q.stb;
    assign busy_o     = s_q.busy;

    // R6: gain never falls and rises by at most one within a window
    p_gain_mono_r6: assert property (@(posedge clk) disable iff (rst)
        s_q.busy |=> ({1'b0, s_q.gain} >= {1'b0, $past(s_q.gain)}) &&
                     ({1'b0, s_q.gain} <= ({1'b0, $past(s_q.gain)} + 3'd1)));

    // R3: strobes only occur inside a window
    p_stb_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        s_q.stb |-> s_q.busy);

    // R4: unsaturated codes are symmetric about common mode
    p_ref_symmetric_r4: assert property (@(posedge clk) disable iff (rst)
        ((s_q.hi != '1) && (s_q.lo != '0)) |->
        (({1'b0, s_q.hi} + {1'b0, s_q.lo}) == {CM_C, 1'b0}));

    // R7: idle outputs hold without a trigger
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!s_q.busy && !trig_i) |=> ($stable(s_q.hi) && $stable(s_q.lo) &&
                                     $stable(s_q.gain) && !s_q.stb));

    // R8: a trigger inside a window never restarts at index 0
    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (s_q.busy && trig_i) |=> !(s_q.stb && (s_q.idx == '0)));

    if (STEP_CYCLES > 1) begin : g_stb_width
        // R3: strobe is a single-cycle pulse
        p_stb_single_r3: assert property (@(posedge clk) disable iff (rst)
            s_q.stb |=> !s_q.stb);
    end
endmodule

// File: tb/tb_tgc_sequencer.sv
module tb_tgc_sequencer;
    localparam int CODE_W = 12;
    localparam int NUM    = 12;
    localparam int STEP   = 5;
    localparam int CM     = 2048;
    localparam int IDX_W  = $clog2(NUM);
    localparam int MAXC   = (1 << CODE_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              trig = 1'b0;
    logic              tbl_we = 1'b0;
    logic [IDX_W-1:0]  tbl_addr = '0;
    logic [CODE_W-1:0] tbl_data = '0;
    logic              sw_we = 1'b0;
    logic [1:0]        sw_sel = '0;
    logic [IDX_W-1:0]  sw_data = '0;
    logic [CODE_W-1:0] ref_hi, ref_lo;
    logic [1:0]        gain_sel;
    logic              upd_stb, busy;

    tgc_sequencer #(
        .CODE_W(CODE_W), .NUM_STEPS(NUM), .STEP_CYCLES(STEP), .CM_CODE(CM)
    ) dut (
        .clk(clk), .rst(rst), .trig_i(trig),
        .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
        .sw_we_i(sw_we), .sw_sel_i(sw_sel), .sw_data_i(sw_data),
        .ref_hi_o(ref_hi), .ref_lo_o(ref_lo), .gain_sel_o(gain_sel),
        .upd_stb_o(upd_stb), .busy_o(busy)
    );

    always #10 clk = ~clk;

    typedef struct { int idx; int hi; int lo; int gain; } item_t;
    item_t exp_q[$];

    int checks = 0, failures = 0;
    int cyc = 0, trig_cyc = 0, last_stb = 0, busy_len = 0;
    logic busy_prev = 1'b0;
    int tbl_m [NUM];
    int sw_m  [3];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: scoreboard pop, spacing and window length
    always @(negedge clk) begin
        if (!rst) begin
            if (upd_stb) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3/R8 unexpected strobe", 1, 0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(ref_hi == e.hi, "R4/R5 ref_hi", ref_hi, e.hi);
                    chk(ref_lo == e.lo, "R4/R5 ref_lo", ref_lo, e.lo);
                    chk(gain_sel == e.gain, "R6 gain_sel", gain_sel, e.gain);
                    if (e.idx == 0)
                        chk(cyc - trig_cyc == 1, "R2 first update delay", cyc - trig_cyc, 1);
                    else
                        chk(cyc - last_stb == STEP, "R3 update spacing", cyc - last_stb, STEP);
                    last_stb = cyc;
                end
            end
            if (busy) busy_len++;
            if (busy_prev && !busy) begin
                chk(busy_len == NUM * STEP, "R7 window length", busy_len, NUM * STEP);
                busy_len = 0;
            end
            busy_prev = busy;
        end
    end

    task automatic write_tbl(input int a, input int d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = IDX_W'(a); tbl_data = CODE_W'(d);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic write_sw(input int s, input int d);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = 2'(s); sw_data = IDX_W'(d);
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // driver: push the expected updates, then trigger
    task automatic run_window();
        int lvl;
        lvl = 0;
        for (int k = 0; k < NUM; k++) begin
            item_t e;
            int s;
            if (lvl < 3 && k >= sw_m[lvl]) lvl++;
            s = CM + tbl_m[k];
            e.idx  = k;
            e.hi   = (s > MAXC) ? MAXC : s;
            e.lo   = (tbl_m[k] > CM) ? 0 : CM - tbl_m[k];
            e.gain = lvl;
            exp_q.push_back(e);
        end
        @(negedge clk);
        trig = 1'b1;
        trig_cyc = cyc;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_idle_and_hold();
        int h, l, g;
        while (busy) @(negedge clk);
        chk(exp_q.size() == 0, "R3 update count", NUM - exp_q.size(), NUM);
        exp_q.delete();
        h = ref_hi; l = ref_lo; g = gain_sel;
        repeat (8) @(negedge clk);
        chk(ref_hi == h && ref_lo == l && gain_sel == g, "R7 hold after window", ref_hi, h);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < NUM; k++) tbl_m[k] = 0;
        sw_m[0] = NUM / 4; sw_m[1] = NUM / 2; sw_m[2] = 3 * NUM / 4;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(ref_hi == CM, "R1 ref_hi reset", ref_hi, CM);
        chk(ref_lo == CM, "R1 ref_lo reset", ref_lo, CM);
        chk(gain_sel == 0, "R1 gain reset", gain_sel, 0);
        chk(!upd_stb && !busy, "R1 strobe/busy reset", {upd_stb, busy}, 0);

        // Window 1 on reset contents (R1 defaults), with intrusions (R8, R9)
        run_window();
        repeat (2 * STEP) @(negedge clk);
        write_tbl(0, 'hABC);
        write_sw(0, 1);
        write_sw(1, 0);
        pulse_trig();
        wait_idle_and_hold();

        // Window 2: same expectations prove the intrusions were ignored (R9)
        run_window();
        wait_idle_and_hold();

        // Idle writes take effect (R9); sel 3 ignored
        for (int k = 0; k < NUM; k++) begin
            tbl_m[k] = 400 - 30 * k;
            write_tbl(k, tbl_m[k]);
        end
        sw_m[0] = 2; sw_m[1] = 5; sw_m[2] = 8;
        write_sw(0, 2); write_sw(1, 5); write_sw(2, 8);
        write_sw(3, 0);
        run_window();
        wait_idle_and_hold();

        // Saturation (R5) and equal / out-of-order switch indices (R6)
        for (int k = 0; k < NUM; k++) begin
            tbl_m[k] = (k % 3 == 0) ? 3000 : ((k % 3 == 1) ? 2047 : 2048);
            write_tbl(k, tbl_m[k]);
        end
        sw_m[0] = 2; sw_m[1] = 2; sw_m[2] = 1;
        write_sw(0, 2); write_sw(1, 2); write_sw(2, 1);
        run_window();
        wait_idle_and_hold();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule